// File: doc/BRIEF.md
# Modem Status Change Detector with Loopback

This block keeps the modem status byte for one serial channel. It watches four active-low handshake inputs from the far side of a serial link (clear to send, data set ready, ring indicator, carrier detect). Each one passes through a two-stage synchronizer. The block reports the live level of each line in the upper half of the status byte. In the lower half it keeps a sticky flag per line that records a change since the last read. Any pending flag raises an interrupt request. Reading the status byte clears the flags.

For self-test, one bit of the modem control byte routes the block's own control outputs back into the status path in place of the external pins. The outputs then map as follows:

| Control output | Status line it drives in loopback |
|---|---|
| request to send | clear to send |
| terminal ready | data set ready |
| spare output A | ring indicator |
| spare output B | carrier detect |

While loopback is on, the external control pins are parked inactive. Change detection and the interrupt request keep working in loopback, so software can exercise its modem-status handler without a cable.

Top module: `modem_status_unit`

## Requirements
- R1: Status bits 4, 5, 6 and 7 show the asserted state (1 = asserted) of clear to send, data set ready, ring indicator and carrier detect. The pins are active low. A pin change appears in the status byte after exactly two rising clock edges and not after one.
- R2: Status bits 0 (clear to send), 1 (data set ready) and 3 (carrier detect) set on either edge of their line. Each one sets on the clock edge after the new level reaches the upper status bits, which is three edges after the pin change.
- R3: Status bit 2 sets only when the ring indicator goes from asserted to deasserted. The assertion of ring indicator leaves bit 2 at 0.
- R4: Change bits 3:0 stay set until a read. A read strobe that is high at a clock edge clears them. A change detected at the same edge as the read stays set.
- R5: irq_o is 1 exactly when at least one of status bits 3:0 is 1.
- R6: Control bit 4 selects loopback. In loopback the status lines take control bit 1 as clear to send, bit 0 as data set ready, bit 2 as ring indicator and bit 3 as carrier detect. The external pins are ignored. Change detection works the same way, including level changes caused by switching the mode.
- R7: In loopback, rts_n_o, dtr_n_o and both aux_n_o bits are held at 1. Outside loopback, rts_n_o is the inverse of control bit 1, dtr_n_o of bit 0, aux_n_o[0] of bit 2 and aux_n_o[1] of bit 3.
- R8: Control bits 7:5 are reserved and have no effect on the status byte or on any output.
- R9: After a synchronous reset held for at least two cycles, status bits 3:0 and irq_o are 0. Status bits 7:4 show the levels present on the pins. A level that was already present during reset sets no change bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cts_n_i | input | 1 | Clear to send, active low, asynchronous |
| dsr_n_i | input | 1 | Data set ready, active low, asynchronous |
| ri_n_i | input | 1 | Ring indicator, active low, asynchronous |
| cd_n_i | input | 1 | Carrier detect, active low, asynchronous |
| mctl_i | input | 8 | Modem control byte (bit 0 terminal ready, 1 request to send, 2 spare A, 3 spare B, 4 loopback, 7:5 reserved) |
| stat_rd_i | input | 1 | Status read strobe, one cycle per read |
| stat_o | output | 8 | Status byte: levels in 7:4, change flags in 3:0 |
| irq_o | output | 1 | Modem-status interrupt request |
| rts_n_o | output | 1 | Request to send pin, active low |
| dtr_n_o | output | 1 | Terminal ready pin, active low |
| aux_n_o | output | 2 | Spare output pins A (bit 0) and B (bit 1), active low |

## Verification
A corrupted previous-level register shows up at the ports as a change bit that is set with no pin activity, or as a missing one. This is visible in stat_o and irq_o one edge after the bad value. A wrong synchronizer depth moves the upper status bits off their two-edge latency, and the bench samples that latency at the edge where it falls. A wrong ring-indicator polarity or read-clear ordering shows in the lower nibble within three edges of the stimulus. A loopback mux fault shows as pin levels leaking into stat_o, or as control pins that do not park at 1.

// File: rtl/msd_pkg.sv
package msd_pkg;

    localparam int NUM_LINES = 4;

    // Line index order inside the status nibbles
    localparam int IDX_CTS = 0;
    localparam int IDX_DSR = 1;
    localparam int IDX_RI  = 2;
    localparam int IDX_CD  = 3;

    // Modem control byte fields
    localparam int CTL_DTR  = 0;
    localparam int CTL_RTS  = 1;
    localparam int CTL_AUXA = 2;
    localparam int CTL_AUXB = 3;
    localparam int CTL_LOOP = 4;

    typedef struct packed {
        logic cd;
        logic ri;
        logic dsr;
        logic cts;
    } modem_lines_t;

    typedef struct packed {
        logic       rts_n;
        logic       dtr_n;
        logic [1:0] aux_n;
    } ctl_pins_t;

    function automatic modem_lines_t loop_lines(input logic [3:0] ctl);
        modem_lines_t l;
        l.cts = ctl[CTL_RTS];
        l.dsr = ctl[CTL_DTR];
        l.ri  = ctl[CTL_AUXA];
        l.cd  = ctl[CTL_AUXB];
        return l;
    endfunction

    function automatic ctl_pins_t drive_pins(input logic [3:0] ctl, input logic loop_on);
        ctl_pins_t p;
        if (loop_on) begin
            p = '{rts_n: 1'b1, dtr_n: 1'b1, aux_n: 2'b11};
        end else begin
            p.rts_n    = ~ctl[CTL_RTS];
            p.dtr_n    = ~ctl[CTL_DTR];
            p.aux_n[0] = ~ctl[CTL_AUXA];
            p.aux_n[1] = ~ctl[CTL_AUXB];
        end
        return p;
    endfunction

endpackage

// File: rtl/msd_sync.sv
module msd_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        stg[0] <= d_i;
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        always_ff @(posedge clk) begin
            stg[k] <= stg[k-1];
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/msd_src_sel.sv
module msd_src_sel
    import msd_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  modem_lines_t ext_i,
    input  logic [3:0]   ctl_i,
    input  logic         loop_i,
    output modem_lines_t line_o,
    output ctl_pins_t    pins_o
);
    always_comb begin
        line_o = loop_i ? loop_lines(ctl_i) : ext_i;
        pins_o = drive_pins(ctl_i, loop_i);
    end

    // Pins cannot disturb the lines while loopback stays on
    AST_LOOP_PINS_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (loop_i && $past(loop_i) && $stable(ctl_i)) |-> $stable(line_o)); // R6
endmodule

// File: rtl/msd_delta.sv
module msd_delta
    import msd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] cur_i,
    input  logic                 rd_i,
    output logic [NUM_LINES-1:0] delta_o
);
    logic [NUM_LINES-1:0] prev_q;
    logic [NUM_LINES-1:0] hit;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_edge
        if (i == IDX_RI) begin : g_trail
            assign hit[i] = prev_q[i] & ~cur_i[i];
        end else begin : g_any
            assign hit[i] = prev_q[i] ^ cur_i[i];
        end
    end

    always_ff @(posedge clk) begin
        prev_q <= cur_i;
        if (rst) begin
            delta_o <= '0;
        end else begin
            delta_o <= (rd_i ? '0 : delta_o) | hit;
        end
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_chk
        if (i != IDX_RI) begin : g_both
            AST_EDGE_SETS: assert property (@(posedge clk) disable iff (rst)
                (cur_i[i] != prev_q[i]) |=> delta_o[i]); // R2
        end
        AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
            (delta_o[i] && !rd_i) |=> delta_o[i]); // R4
    end

    AST_RI_RISE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!delta_o[IDX_RI] && !prev_q[IDX_RI] && cur_i[IDX_RI]) |=> !delta_o[IDX_RI]); // R3

    AST_READ_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (rd_i && (cur_i == prev_q)) |=> (delta_o == '0)); // R4
endmodule

// File: rtl/modem_status_unit.sv
module modem_status_unit
    import msd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cts_n_i,
    input  logic       dsr_n_i,
    input  logic       ri_n_i,
    input  logic       cd_n_i,
    input  logic [7:0] mctl_i,
    input  logic       stat_rd_i,
    output logic [7:0] stat_o,
    output logic       irq_o,
    output logic       rts_n_o,
    output logic       dtr_n_o,
    output logic [1:0] aux_n_o
);
    logic [NUM_LINES-1:0] pins_n;
    logic [NUM_LINES-1:0] pins_n_s;
    modem_lines_t         ext_lines;
    modem_lines_t         lines;
    ctl_pins_t            pins;
    logic [NUM_LINES-1:0] delta;
    logic                 unused_rsvd;

    assign pins_n      = {cd_n_i, ri_n_i, dsr_n_i, cts_n_i};
    assign unused_rsvd = ^mctl_i[7:5];

    msd_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d_i (pins_n),
        .q_o (pins_n_s)
    );

    assign ext_lines = modem_lines_t'(~pins_n_s);

    msd_src_sel u_sel (
        .clk    (clk),
        .rst    (rst),
        .ext_i  (ext_lines),
        .ctl_i  (mctl_i[3:0]),
        .loop_i (mctl_i[CTL_LOOP]),
        .line_o (lines),
        .pins_o (pins)
    );

    msd_delta u_delta (
        .clk     (clk),
        .rst     (rst),
        .cur_i   (lines),
        .rd_i    (stat_rd_i),
        .delta_o (delta)
    );

    assign stat_o  = {lines, delta};
    assign irq_o   = |delta;
    assign rts_n_o = pins.rts_n;
    assign dtr_n_o = pins.dtr_n;
    assign aux_n_o = pins.aux_n;

    AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !stat_rd_i) |=> irq_o); // R5
endmodule

// File: tb/tb_modem_status_unit.sv
module tb_modem_status_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 17;
    // {control byte, pins_n {cd,ri,dsr,cts}, expected status}
    localparam logic [19:0] VEC [NVEC] = '{
        20'h00F00, 20'h00E11, 20'h00C32, 20'h00870, 20'h000F8,
        20'h004B4, 20'h00F0B, 20'h10F00, 20'h12F11, 20'h13F32,
        20'h17F70, 20'h1FFF8, 20'h1BFB4, 20'h1B0B0, 20'h0B0F0,
        20'h00F0F, 20'hE2F00
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, cd_n = 1'b1;
    logic [7:0] mctl = 8'h00;
    logic       rd = 1'b0;
    logic [7:0] stat;
    logic       irq, rts_n, dtr_n;
    logic [1:0] aux_n;
    int         n_run = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    modem_status_unit dut (
        .clk(clk), .rst(rst), .cts_n_i(cts_n), .dsr_n_i(dsr_n), .ri_n_i(ri_n),
        .cd_n_i(cd_n), .mctl_i(mctl), .stat_rd_i(rd), .stat_o(stat), .irq_o(irq),
        .rts_n_o(rts_n), .dtr_n_o(dtr_n), .aux_n_o(aux_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic set_pins(input logic [3:0] p);
        {cd_n, ri_n, dsr_n, cts_n} = p;
    endtask

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        tick(20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R9: reset with inactive pins
        tick(5);
        rst = 1'b0;
        tick(1);
        chk("R9 reset status idle pins", {24'h0, stat}, 32'h00);
        chk("R9 reset irq", {31'h0, irq}, 0);

        // Vector table: R1 R2 R3 R6 R7 R8, each followed by a clearing read (R4 R5)
        for (int v = 0; v < NVEC; v++) begin
            logic [7:0] m;
            logic [3:0] exp_pins;
            m = VEC[v][19:12];
            mctl = m;
            set_pins(VEC[v][11:8]);
            tick(4);
            chk($sformatf("R1 R2 R3 R6 R8 vector %0d status", v), {24'h0, stat}, {24'h0, VEC[v][7:0]});
            chk($sformatf("R5 vector %0d irq", v), {31'h0, irq}, {31'h0, |VEC[v][3:0]});
            exp_pins = m[4] ? 4'hF : {~m[1], ~m[0], ~m[3], ~m[2]};
            chk($sformatf("R7 R8 vector %0d pins", v), {28'h0, rts_n, dtr_n, aux_n}, {28'h0, exp_pins});
            rd = 1'b1;
            tick(1);
            rd = 1'b0;
            chk($sformatf("R4 vector %0d read clears", v), {28'h0, stat[3:0]}, 32'h0);
        end

        // R9: reset with all pins asserted
        mctl = 8'h00;
        set_pins(4'h0);
        rst = 1'b1;
        tick(5);
        rst = 1'b0;
        tick(1);
        chk("R9 reset follows pins", {24'h0, stat}, 32'hF0);
        tick(3);
        chk("R9 no delta from reset levels", {24'h0, stat}, 32'hF0);
        chk("R9 irq quiet", {31'h0, irq}, 0);

        // R1/R2 latency: deassert clear to send
        cts_n = 1'b1;
        tick(1);
        chk("R1 not visible after one edge", {24'h0, stat}, 32'hF0);
        tick(1);
        chk("R1 visible after two edges", {24'h0, stat}, 32'hE0);
        tick(1);
        chk("R2 delta one edge later", {24'h0, stat}, 32'hE1);
        rd = 1'b1;
        tick(1);
        rd = 1'b0;
        chk("R4 read clears pending", {24'h0, stat}, 32'hE0);

        // R4: change coinciding with read stays set
        dsr_n = 1'b1;
        tick(2);
        rd = 1'b1;
        tick(1);
        rd = 1'b0;
        chk("R4 coincident change kept", {24'h0, stat}, 32'hC2);
        chk("R5 irq from kept change", {31'h0, irq}, 1);
        tick(5);
        chk("R4 still sticky", {24'h0, stat}, 32'hC2);
        rd = 1'b1;
        tick(1);
        rd = 1'b0;
        chk("R4 later read clears", {24'h0, stat}, 32'hC0);

        // R3: ring indicator rise then fall
        ri_n = 1'b1;
        tick(4);
        chk("R3 ring trailing edge", {24'h0, stat}, 32'h84);
        rd = 1'b1;
        tick(1);
        rd = 1'b0;
        ri_n = 1'b0;
        tick(4);
        chk("R3 ring leading edge quiet", {24'h0, stat}, 32'hC0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule